// File: doc/BRIEF.md
# DMA channel descriptor sequencer

This block is the control core of a single DMA channel. Software loads a source address, a destination address, a link pointer, a control word and a configuration word through a word-indexed register port. Once enabled, the channel emits one transfer strobe per cycle in which the datapath requests service. Each strobe carries the current source and destination addresses. After each transfer the addresses step by the configured width when their increment bits are set, and the remaining count drops by one.

When the count reaches zero the descriptor is finished. The channel may raise a terminal-count interrupt. It then stops if the link pointer is zero. Otherwise it reads the next four-word descriptor from memory (source, destination, link, control, at consecutive word addresses) over a simple word-read port and continues with it. A halt bit blocks new requests while the datapath drains. An active flag lets software wait for the drain before it clears enable.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset every readable register (index 0 source, 1 destination, 2 link, 3 control, 4 configuration, 5 status) reads zero, and `xfer_req`, `rd_req`, `irq_tc` and `irq_err` are low. Reads return, one cycle later, the register selected by `reg_addr`.
- R2: While the channel runs, is not halted and has a nonzero count, each cycle with `src_req` high yields one `xfer_req` pulse on the next cycle. The pulse carries the addresses current before the step, and the count (control bits 11:0) drops by one. A descriptor of count N gives exactly N pulses.
- R3: Control bit 12 (source) and bit 13 (destination) make the matching address advance after each transfer by the step that control bits 15:14 select: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 give 4 bytes. An address whose bit is clear stays fixed. Addresses wrap modulo 2^32.
- R4: When a running descriptor reaches a count of zero (including one loaded with zero), status bit 0 is set if control bit 16 is set and is left unchanged otherwise. `irq_tc` equals status bit 0 AND configuration bit 2.
- R5: If the finished descriptor's link is zero, hardware clears configuration bit 0 (enable) and no further `xfer_req` occurs.
- R6: If the link is nonzero, the channel reads words at link, link+4, link+8 and link+12. It loads them as source, destination, link and control, then resumes transfers with them.
- R7: An error response during a descriptor read stops the channel, clears enable and sets status bit 1. `irq_err` equals status bit 1 AND configuration bit 3.
- R8: With configuration bit 1 (halt) set, `src_req` is ignored and the count is held. Clearing halt resumes the descriptor where it stopped.
- R9: Configuration bit 4 reads 1 while `dp_busy` is high or a transfer strobe is out, and 0 otherwise. Writes to it have no effect.
- R10: Writing 1 to a status bit clears it. If hardware sets the bit in the same cycle, the bit ends up set.
- R11: The link register always reads with bits 1:0 zero, whatever was written there.
- R12: Clearing enable while transfers run takes effect from the cycle after the write. A transfer issued at the same edge as the write still completes, and the count left reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| src_req | input | 1 | Datapath requests one transfer |
| dp_busy | input | 1 | Datapath still holds buffered data |
| xfer_req | output | 1 | One-cycle transfer strobe |
| xfer_src | output | 32 | Source address of the strobed transfer |
| xfer_dst | output | 32 | Destination address of the strobed transfer |
| rd_req | output | 1 | Descriptor word read request, held until acknowledged |
| rd_addr | output | 32 | Descriptor word address |
| rd_ack | input | 1 | Read response valid |
| rd_err | input | 1 | Read response is an error (with `rd_ack`) |
| rd_data | input | 32 | Read response data |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |

## Verification
Two status functions can land on the same clock edge: hardware setting the terminal-count bit at the end of a descriptor, and a software write-one-to-clear of that bit. The bench first leaves the bit set with an earlier descriptor. It then counts transfer strobes on a two-transfer descriptor and drives the clearing write right after the last strobe, so the write is sampled at exactly the edge where the count-zero check fires. The status read afterwards must show the bit still set, and a later lone clear must bring it to zero.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2
  } dds_state_e;

  // register word indices
  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_LINK = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_CFG  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;

  // words per linked descriptor: src, dst, link, ctrl
  localparam int DESC_WORDS = 4;

  function automatic logic [2:0] step_bytes(input logic [1:0] code);
    case (code)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dds_addr_unit.sv
module dds_addr_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic         desc_ld,
  input  logic [W-1:0] desc_data,
  input  logic         step_en,
  input  logic         inc,
  input  logic [2:0]   step,
  output logic [W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (desc_ld) begin
      addr <= desc_data;
    end else if (sw_we) begin
      addr <= sw_data;
    end else if (step_en && inc) begin
      addr <= addr + {{(W-3){1'b0}}, step};
    end
  end

endmodule

// File: rtl/dds_fetch.sv
module dds_fetch
  import dds_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         abort,
  input  logic [W-1:0]                 base,
  output logic                         rd_req,
  output logic [W-1:0]                 rd_addr,
  input  logic                         rd_ack,
  input  logic                         rd_err,
  input  logic [W-1:0]                 rd_data,
  output logic                         done,
  output logic                         fail,
  output logic [DESC_WORDS-1:0][W-1:0] desc_words
);

  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [IDX_W-1:0] idx;
  logic [W-1:0]     shadow [DESC_WORDS];
  logic             take;

  assign take = rd_req && rd_ack && !rd_err && !abort;

  // descriptor buffer kept free of reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (take) shadow[idx] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      idx     <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (abort) begin
        rd_req <= 1'b0;
      end else if (start) begin
        rd_req  <= 1'b1;
        rd_addr <= base;
        idx     <= '0;
      end else if (rd_req && rd_ack) begin
        if (rd_err) begin
          rd_req <= 1'b0;
          fail   <= 1'b1;
        end else if (idx == LAST_IDX) begin
          rd_req <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          rd_addr <= rd_addr + W'(4);
        end
      end
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_words
    assign desc_words[g] = shadow[g];
  end

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dds_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         src_req,
  input  logic         dp_busy,
  output logic         xfer_req,
  output logic [W-1:0] xfer_src,
  output logic [W-1:0] xfer_dst,
  output logic         rd_req,
  output logic [W-1:0] rd_addr,
  input  logic         rd_ack,
  input  logic         rd_err,
  input  logic [W-1:0] rd_data,
  output logic         irq_tc,
  output logic         irq_err
);

  // control word layout derived from the count width
  localparam int SI_B      = CNT_W;
  localparam int DI_B      = CNT_W + 1;
  localparam int WC_LO     = CNT_W + 2;
  localparam int TC_B      = CNT_W + 4;
  localparam int CTRL_USED = CNT_W + 5;

  dds_state_e state;

  logic             en_q, halt_q, tcm_q, erm_q;
  logic             tc_stat_q, err_stat_q;
  logic [W-1:0]     link_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sinc_q, dinc_q, tcen_q;
  logic [1:0]       wcode_q;

  logic we_src, we_dst, we_link, we_ctrl, we_cfg, we_stat;
  logic issue, term, chain, fetch_abort, desc_ld;
  logic f_done, f_fail, act;
  logic [2:0] step_b;
  logic [DESC_WORDS-1:0][W-1:0] desc_words;
  logic [1:0] au_we, au_inc;
  logic [W-1:0] au_addr [2];
  logic [W-1:0] rdata_n;
  logic [W-1:0] ctrl_w;
  logic         unused_desc;

  assign we_src  = reg_wr && (reg_addr == RA_SRC);
  assign we_dst  = reg_wr && (reg_addr == RA_DST);
  assign we_link = reg_wr && (reg_addr == RA_LINK);
  assign we_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign we_cfg  = reg_wr && (reg_addr == RA_CFG);
  assign we_stat = reg_wr && (reg_addr == RA_STAT);

  assign issue       = (state == ST_RUN) && en_q && !halt_q && (cnt_q != '0) && src_req;
  assign term        = (state == ST_RUN) && en_q && (cnt_q == '0);
  assign chain       = term && (link_q != '0);
  assign fetch_abort = (state == ST_FETCH) && !en_q;
  assign desc_ld     = (state == ST_FETCH) && en_q && f_done;
  assign step_b      = step_bytes(wcode_q);
  assign act         = dp_busy || xfer_req;
  assign ctrl_w      = desc_words[3];
  assign unused_desc = ^{ctrl_w[W-1:CTRL_USED], desc_words[2][1:0]};

  // source and destination address units share one structure
  assign au_we  = {we_dst, we_src};
  assign au_inc = {dinc_q, sinc_q};

  for (genvar g = 0; g < 2; g++) begin : g_addr
    dds_addr_unit #(.W(W)) u_au (
      .clk       (clk),
      .rst       (rst),
      .sw_we     (au_we[g]),
      .sw_data   (reg_wdata),
      .desc_ld   (desc_ld),
      .desc_data (desc_words[g]),
      .step_en   (issue),
      .inc       (au_inc[g]),
      .step      (step_b),
      .addr      (au_addr[g])
    );
  end

  dds_fetch #(.W(W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .start      (chain),
    .abort      (fetch_abort),
    .base       (link_q),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_err     (rd_err),
    .rd_data    (rd_data),
    .done       (f_done),
    .fail       (f_fail),
    .desc_words (desc_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      en_q       <= 1'b0;
      halt_q     <= 1'b0;
      tcm_q      <= 1'b0;
      erm_q      <= 1'b0;
      tc_stat_q  <= 1'b0;
      err_stat_q <= 1'b0;
      link_q     <= '0;
      cnt_q      <= '0;
      sinc_q     <= 1'b0;
      dinc_q     <= 1'b0;
      tcen_q     <= 1'b0;
      wcode_q    <= '0;
      xfer_req   <= 1'b0;
      xfer_src   <= '0;
      xfer_dst   <= '0;
    end else begin
      xfer_req <= issue;
      if (issue) begin
        xfer_src <= au_addr[0];
        xfer_dst <= au_addr[1];
      end

      // software side first; hardware updates below take priority
      if (we_cfg) begin
        en_q   <= reg_wdata[0];
        halt_q <= reg_wdata[1];
        tcm_q  <= reg_wdata[2];
        erm_q  <= reg_wdata[3];
      end
      if (we_link) link_q <= {reg_wdata[W-1:2], 2'b00};
      if (we_ctrl) begin
        cnt_q   <= reg_wdata[CNT_W-1:0];
        sinc_q  <= reg_wdata[SI_B];
        dinc_q  <= reg_wdata[DI_B];
        wcode_q <= reg_wdata[WC_LO+1:WC_LO];
        tcen_q  <= reg_wdata[TC_B];
      end
      if (we_stat) begin
        tc_stat_q  <= tc_stat_q  & ~reg_wdata[0];
        err_stat_q <= err_stat_q & ~reg_wdata[1];
      end

      case (state)
        ST_IDLE: begin
          if (en_q) state <= ST_RUN;
        end
        ST_RUN: begin
          if (!en_q) begin
            state <= ST_IDLE;
          end else if (issue) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (term) begin
            if (tcen_q) tc_stat_q <= 1'b1;
            if (link_q == '0) begin
              en_q  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (!en_q) begin
            state <= ST_IDLE;
          end else if (f_fail) begin
            en_q       <= 1'b0;
            err_stat_q <= 1'b1;
            state      <= ST_IDLE;
          end else if (f_done) begin
            link_q  <= {desc_words[2][W-1:2], 2'b00};
            cnt_q   <= ctrl_w[CNT_W-1:0];
            sinc_q  <= ctrl_w[SI_B];
            dinc_q  <= ctrl_w[DI_B];
            wcode_q <= ctrl_w[WC_LO+1:WC_LO];
            tcen_q  <= ctrl_w[TC_B];
            state   <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_SRC:  rdata_n = au_addr[0];
      RA_DST:  rdata_n = au_addr[1];
      RA_LINK: rdata_n = link_q;
      RA_CTRL: rdata_n = {{(W-CTRL_USED){1'b0}}, tcen_q, wcode_q, dinc_q, sinc_q, cnt_q};
      RA_CFG:  rdata_n = {{(W-5){1'b0}}, act, erm_q, tcm_q, halt_q, en_q};
      RA_STAT: rdata_n = {{(W-2){1'b0}}, err_stat_q, tc_stat_q};
      default: rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rdata_n;
  end

  assign irq_tc  = tc_stat_q & tcm_q;
  assign irq_err = err_stat_q & erm_q;

endmodule

// File: rtl/dds_chk.sv
module dds_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_req,
  input logic             src_req,
  input logic             halt_q,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             we_ctrl,
  input logic             rd_req,
  input logic [W-1:0]     rd_addr,
  input logic             rd_ack,
  input logic             rd_err,
  input logic             irq_tc,
  input logic             tcm_q,
  input logic             irq_err,
  input logic             erm_q
);

  p_xfer_on_request_r2: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> $past(src_req));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !$past(we_ctrl)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_halt_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> !xfer_req);

  p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !xfer_req);

  p_fetch_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[1:0] == 2'b00));

  p_fetch_err_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack && rd_err && en_q) |-> ##2 !en_q);

  p_tc_masked_r4: assert property (@(posedge clk) disable iff (rst)
    irq_tc |-> tcm_q);

  p_err_masked_r7: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> erm_q);

endmodule

bind dma_desc_seq dds_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .xfer_req (xfer_req),
  .src_req  (src_req),
  .halt_q   (halt_q),
  .en_q     (en_q),
  .cnt_q    (cnt_q),
  .we_ctrl  (we_ctrl),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_ack   (rd_ack),
  .rd_err   (rd_err),
  .irq_tc   (irq_tc),
  .tcm_q    (tcm_q),
  .irq_err  (irq_err),
  .erm_q    (erm_q)
);

// File: tb/sim_dma_desc_seq.sv
`timescale 1ns/1ps
module sim_dma_desc_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_req = 1'b0;
  logic        dp_busy = 1'b0;
  logic        xfer_req;
  logic [31:0] xfer_src, xfer_dst;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic        rd_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic        irq_tc, irq_err;

  always #2 clk = ~clk;

  dma_desc_seq u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .dp_busy(dp_busy), .xfer_req(xfer_req), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .irq_tc(irq_tc), .irq_err(irq_err)
  );

  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_LINK = 3'd2,
                         A_CTRL = 3'd3, A_CFG = 3'd4, A_STAT = 3'd5;

  int errs = 0, checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory slave answering one word per cycle
  logic [31:0] mem [0:63];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] flog [0:7];
  int fn = 0;
  always @(negedge clk) begin
    rd_ack  <= rd_req;
    rd_data <= mem[rd_addr[7:2]];
    rd_err  <= rd_req && (rd_addr == err_addr);
    if (rd_req && fn < 8) flog[fn] = rd_addr;
    if (rd_req) fn++;
  end

  // transfer monitor against bench-computed expectations
  logic [31:0] exp_s [0:15];
  logic [31:0] exp_d [0:15];
  int nx = 0, mon_bad = 0;
  logic [31:0] bad_act, bad_exp;
  always @(negedge clk) begin
    if (xfer_req) begin
      if (nx < 16 && (xfer_src !== exp_s[nx] || xfer_dst !== exp_d[nx])) begin
        mon_bad++;
        bad_act = xfer_src ^ xfer_dst;
        bad_exp = exp_s[nx] ^ exp_d[nx];
      end
      nx++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(A_CFG, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int n, input bit si, input bit di,
                                          input logic [1:0] w, input bit tc);
    return {15'b0, tc, w, di, si, 12'(n)};
  endfunction

  function automatic logic [31:0] stp(input logic [1:0] w);
    return (w == 2'd0) ? 32'd1 : (w == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic plan(input int base, input logic [31:0] s, input logic [31:0] d,
                      input int n, input bit si, input bit di, input logic [1:0] w);
    for (int k = 0; k < n; k++) begin
      exp_s[base+k] = si ? s + 32'(k) * stp(w) : s;
      exp_d[base+k] = di ? d + 32'(k) * stp(w) : d;
    end
  endtask

  typedef struct packed {
    logic [31:0] s;
    logic [31:0] d;
    logic [11:0] n;
    logic        si;
    logic        di;
    logic [1:0]  w;
    logic        tc;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0100, 32'h0000_0200, 12'd3, 1'b1, 1'b1, 2'd2, 1'b1},
    '{32'h0000_0010, 32'h0000_0800, 12'd4, 1'b1, 1'b0, 2'd0, 1'b1},
    '{32'h0000_1002, 32'h0000_2002, 12'd2, 1'b0, 1'b1, 2'd1, 1'b0},
    '{32'h0000_0040, 32'h0000_0050, 12'd5, 1'b1, 1'b1, 2'd3, 1'b1},
    '{32'hFFFF_FFFC, 32'h0000_0000, 12'd2, 1'b1, 1'b1, 2'd2, 1'b1}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 32'h0);
    end
    chk("R1 outputs idle", {28'b0, xfer_req, rd_req, irq_tc, irq_err}, 32'h0);

    // table-driven single descriptors: R2 R3 R4 R5
    src_req = 1'b1;
    for (int i = 0; i < NV; i++) begin
      plan(0, VEC[i].s, VEC[i].d, int'(VEC[i].n), VEC[i].si, VEC[i].di, VEC[i].w);
      wr(A_SRC, VEC[i].s); wr(A_DST, VEC[i].d); wr(A_LINK, 32'h0);
      wr(A_CTRL, mk_ctrl(int'(VEC[i].n), VEC[i].si, VEC[i].di, VEC[i].w, VEC[i].tc));
      wr(A_STAT, 32'h3);
      nx = 0; mon_bad = 0;
      wr(A_CFG, 32'h5);
      wait_idle();
      chk($sformatf("R2 vec %0d transfer count", i), 32'(nx), 32'(VEC[i].n));
      chk($sformatf("R3 vec %0d address mismatches", i), 32'(mon_bad), 32'h0);
      rd(A_SRC, v);
      chk($sformatf("R3 vec %0d final source", i), v,
          VEC[i].si ? VEC[i].s + 32'(VEC[i].n) * stp(VEC[i].w) : VEC[i].s);
      rd(A_DST, v);
      chk($sformatf("R3 vec %0d final destination", i), v,
          VEC[i].di ? VEC[i].d + 32'(VEC[i].n) * stp(VEC[i].w) : VEC[i].d);
      rd(A_STAT, v);
      chk($sformatf("R4 vec %0d tc status", i), v, {31'b0, VEC[i].tc});
      chk($sformatf("R4 vec %0d irq_tc", i), {31'b0, irq_tc}, {31'b0, VEC[i].tc});
      rd(A_CFG, v);
      chk($sformatf("R5 vec %0d enable cleared", i), {31'b0, v[0]}, 32'h0);
    end

    // R5 no strobes after stop
    k = nx;
    repeat (10) @(negedge clk);
    chk("R5 quiet after stop", 32'(nx), 32'(k));

    // R6 R11 chained descriptor
    mem[16] = 32'h0000_3000; mem[17] = 32'h0000_4000;
    mem[18] = 32'h0000_0000; mem[19] = mk_ctrl(3, 1, 1, 2'd2, 1);
    plan(0, 32'h1000, 32'h2000, 2, 1, 1, 2'd1);
    plan(2, 32'h3000, 32'h4000, 3, 1, 1, 2'd2);
    wr(A_SRC, 32'h1000); wr(A_DST, 32'h2000); wr(A_LINK, 32'h0000_0043);
    rd(A_LINK, v);
    chk("R11 link low bits read zero", v, 32'h0000_0040);
    wr(A_CTRL, mk_ctrl(2, 1, 1, 2'd1, 0));
    wr(A_STAT, 32'h3);
    nx = 0; mon_bad = 0; fn = 0;
    wr(A_CFG, 32'h5);
    wait_idle();
    chk("R6 total transfers across chain", 32'(nx), 32'd5);
    chk("R6 address mismatches across chain", 32'(mon_bad), 32'h0);
    chk("R6 fetch word count", 32'(fn), 32'd4);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R6 fetch address %0d", i), flog[i], 32'h40 + 32'(4 * i));
    rd(A_SRC, v);
    chk("R6 source after loaded descriptor", v, 32'h0000_300C);

    // R7 fetch error with masked interrupt
    mem[32] = 32'h0000_5000;
    err_addr = 32'h0000_0084;
    plan(0, 32'h100, 32'h200, 1, 0, 0, 2'd2);
    wr(A_SRC, 32'h100); wr(A_DST, 32'h200); wr(A_LINK, 32'h80);
    wr(A_CTRL, mk_ctrl(1, 0, 0, 2'd2, 0));
    wr(A_STAT, 32'h3);
    nx = 0;
    wr(A_CFG, 32'h5);
    wait_idle();
    rd(A_STAT, v);
    chk("R7 error status set", v, 32'h2);
    chk("R7 irq_err masked", {31'b0, irq_err}, 32'h0);
    chk("R7 transfers before error", 32'(nx), 32'd1);
    wr(A_CFG, 32'h8);
    chk("R7 irq_err unmasked", {31'b0, irq_err}, 32'h1);
    wr(A_STAT, 32'h2);
    chk("R7 irq_err cleared", {31'b0, irq_err}, 32'h0);
    err_addr = 32'hFFFF_FFFF;

    // R8 R9 halt and active
    plan(0, 32'h600, 32'h700, 4, 1, 1, 2'd2);
    wr(A_SRC, 32'h600); wr(A_DST, 32'h700); wr(A_LINK, 32'h0);
    wr(A_CTRL, mk_ctrl(4, 1, 1, 2'd2, 1));
    nx = 0; mon_bad = 0;
    wr(A_CFG, 32'h7);
    repeat (10) @(negedge clk);
    chk("R8 no transfers while halted", 32'(nx), 32'h0);
    rd(A_CTRL, v);
    chk("R8 count held while halted", {20'b0, v[11:0]}, 32'd4);
    dp_busy = 1'b1;
    rd(A_CFG, v);
    chk("R9 active with buffered data", {31'b0, v[4]}, 32'h1);
    dp_busy = 1'b0;
    wr(A_CFG, 32'h17);
    rd(A_CFG, v);
    chk("R9 active drops and ignores write", {31'b0, v[4]}, 32'h0);
    wr(A_CFG, 32'h5);
    wait_idle();
    chk("R8 resumed transfers", 32'(nx), 32'd4);
    chk("R8 resumed addresses", 32'(mon_bad), 32'h0);

    // R4 zero-count descriptor
    wr(A_STAT, 32'h3);
    wr(A_CTRL, mk_ctrl(0, 0, 0, 2'd0, 1));
    nx = 0;
    wr(A_CFG, 32'h5);
    wait_idle();
    chk("R4 zero count gives no transfers", 32'(nx), 32'h0);
    rd(A_STAT, v);
    chk("R4 zero count sets tc", v, 32'h1);

    // R10 clear collides with hardware set (tc status already 1)
    plan(0, 32'h900, 32'hA00, 2, 0, 0, 2'd0);
    wr(A_SRC, 32'h900); wr(A_DST, 32'hA00);
    wr(A_CTRL, mk_ctrl(2, 0, 0, 2'd0, 1));
    nx = 0;
    wr(A_CFG, 32'h5);
    k = 0;
    for (int i = 0; i < 50 && k < 2; i++) begin
      @(negedge clk);
      if (xfer_req) k++;
    end
    wr(A_STAT, 32'h1);
    rd(A_STAT, v);
    chk("R10 hardware set wins over clear", v, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v);
    chk("R10 lone clear", v, 32'h0);

    // R12 disable mid-run
    plan(0, 32'hB00, 32'hC00, 10, 1, 0, 2'd2);
    wr(A_SRC, 32'hB00); wr(A_DST, 32'hC00);
    wr(A_CTRL, mk_ctrl(10, 1, 0, 2'd2, 1));
    nx = 0; mon_bad = 0;
    wr(A_CFG, 32'h5);
    k = 0;
    for (int i = 0; i < 50 && k < 3; i++) begin
      @(negedge clk);
      if (xfer_req) k++;
    end
    wr(A_CFG, 32'h0);
    repeat (8) @(negedge clk);
    chk("R12 transfers after disable", 32'(nx), 32'd4);
    rd(A_CTRL, v);
    chk("R12 remaining count", {20'b0, v[11:0]}, 32'd6);
    rd(A_SRC, v);
    chk("R12 source stopped", v, 32'hB10);

    src_req = 1'b0;
    summary();
    $finish;
  end

endmodule